// File: doc/BRIEF.md
# Slot DMA Request Sequencer

This block lets logic on an expansion card stop the host CPU and take the slot bus for a burst of direct memory transfers. The card logic gives a start pulse together with a transfer count, a first address and a direction. The sequencer then waits for the next falling edge of the 1 MHz slot phase and pulls the active-low DMA request low. It drives one address per slot cycle, counting up, for as many slot cycles as the count asks. At the end it lets go of the request line by driving it high for one fast-clock tick and then floating it, because the pull-up on the backplane is weak.

All timing comes from a fast reference clock that samples the slot phase. Every edge of the request falls a fixed number of fast ticks after a detected phase fall. The address and direction follow a second fixed delay later. Parameter checks at elaboration keep both delays inside the allowed windows after the phase edge (100 ns for the request, 120 ns for a stable address). Firmware must load the DMA bank register before it issues a start, because the sequencer only drives the low address bits. Transfers are best run with the system at 1 MHz. If a burst begins during a slow cycle, the system stays slow for as long as the request is held.

Top module: `slot_dma_seq`

## Requirements
- R1: During and right after reset, the request line is not driven (`dma_req_oe` = 0), the address and direction are not driven, and `busy` and `done` are 0.
- R2: A start with a non-zero count while idle raises `busy` on the next clock. The request is then driven low (`dma_req_oe` = 1, `dma_req_val` = 0) at the first request point of a slot cycle. A request point lies `SYNC_STAGES + REQ_DLY - 1` fast clocks after the first clock edge that samples the slot phase low.
- R3: Each change of the request drive (oe, val) lands exactly on a request point, or on the one fast clock after it.
- R4: The address and direction appear `ADDR_DLY` fast clocks after a request point. They change at no other time, and they are driven only while the request is held low.
- R5: The addresses driven are the start address, then start+1, and so on, one per slot cycle, modulo 2^`ADDR_W`. Exactly `xfer_len` addresses are driven.
- R6: The request stays low for exactly `xfer_len` slot periods. It is released at a request point.
- R7: Release drives the request high (`dma_req_oe` = 1, `dma_req_val` = 1) for one fast clock, with the address already floated. The request line is then floated (`dma_req_oe` = 0).
- R8: `done` is a one-clock pulse on the clock after the release tick, with `busy` already 0. It never occurs at any other time.
- R9: A start with `xfer_len` = 0 is ignored, and so is a start while busy. Neither changes the request line or the address sequence under way.
- R10: While the address is driven, `rw_o` equals the `xfer_write` value captured at start (1 = write to memory, 0 = read).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_ph | input | 1 | 1 MHz slot phase clock, sampled by `clk` |
| start | input | 1 | One-clock start command |
| xfer_len | input | CNT_W | Number of slot cycles to transfer |
| xfer_addr | input | ADDR_W | First transfer address |
| xfer_write | input | 1 | Direction captured at start, 1 = write |
| dma_req_oe | output | 1 | Enable of the open-collector request driver |
| dma_req_val | output | 1 | Level on the request pin while enabled (0 = request, 1 = release pulse) |
| addr_o | output | ADDR_W | Transfer address |
| addr_oe | output | 1 | Address and direction output enable |
| rw_o | output | 1 | Direction, 1 = write |
| busy | output | 1 | A transfer is pending or running |
| done | output | 1 | One-clock pulse after release |

## Verification
All timing is counted in fast clocks from the first edge that samples the slot phase low. Request edges are due `SYNC_STAGES + REQ_DLY - 1` clocks later, the float one clock after the release pulse, new addresses `ADDR_DLY` clocks after the request edge, and `done` on the clock after the release pulse. The bench keeps its own count of clocks since each phase fall, sampling one nanosecond after each rising edge. Every change it sees on the request pair or the address is compared against the exact count at which that change is due. `busy` is checked one clock after start. The hold length is checked as the difference between the assert and release samples, which must equal the count times the slot period.

// File: rtl/slot_dma_pkg.sv
package slot_dma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_REQUEST  = 2'd1,
      ST_TRANSFER = 2'd2,
      ST_RELEASE  = 2'd3
   } dma_state_e;
endpackage

// File: rtl/slot_phase_timer.sv
// Synchronises the slot phase, detects its falling edge and counts fast
// ticks since that edge; flags the request point and the address point.
module slot_phase_timer #(
   parameter int SYNC_STAGES = 2,
   parameter int REQ_DLY     = 4,
   parameter int ADDR_DLY    = 6,
   parameter int TICK_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_ph,
   output logic              at_req,
   output logic              at_addr,
   output logic [TICK_W-1:0] tick
);
   localparam logic [TICK_W-1:0] REQ_T  = TICK_W'(REQ_DLY);
   localparam logic [TICK_W-1:0] ADDR_T = TICK_W'(REQ_DLY + ADDR_DLY);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("slot_phase_timer: SYNC_STAGES must be at least 2");
   end
   if (REQ_DLY < 1 || ADDR_DLY < 1) begin : g_bad_dly
      $error("slot_phase_timer: delays must be at least one tick");
   end
   if (REQ_DLY + ADDR_DLY + 2 >= (1 << TICK_W) - 1) begin : g_bad_tick
      $error("slot_phase_timer: TICK_W too narrow for the delays");
   end

   logic sync_q [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b1;
      else        sync_q[0] <= slot_ph;
   end

   for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[g] <= 1'b1;
         else        sync_q[g] <= sync_q[g-1];
      end
   end

   logic ph_fall;
   assign ph_fall = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES-2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tick <= '1;
      else if (ph_fall)     tick <= TICK_W'(1);
      else if (tick != '1)  tick <= tick + TICK_W'(1);
   end

   assign at_req  = (tick == REQ_T);
   assign at_addr = (tick == ADDR_T);

   // R3: a request point can only follow a phase fall, never repeat within it
   p_req_point_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      at_req |=> !at_req);
endmodule

// File: rtl/slot_dma_ctrl.sv
// Four-state sequencer: idle, waiting for a request point, transferring,
// one-tick release pulse.
module slot_dma_ctrl
   import slot_dma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       len_zero,
   input  logic       at_req,
   input  logic       last,
   output dma_state_e state,
   output logic       load,
   output logic       step,
   output logic       finish,
   output logic       done
);
   dma_state_e state_nx;

   assign load   = (state == ST_IDLE) && start && !len_zero;
   assign step   = (state == ST_TRANSFER) && at_req && !last;
   assign finish = (state == ST_TRANSFER) && at_req && last;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:     if (load)   state_nx = ST_REQUEST;
         ST_REQUEST:  if (at_req) state_nx = ST_TRANSFER;
         ST_TRANSFER: if (finish) state_nx = ST_RELEASE;
         ST_RELEASE:              state_nx = ST_IDLE;
         default:                 state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= (state == ST_RELEASE);
      end
   end

   p_release_one_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RELEASE) |=> (state == ST_IDLE));

   p_done_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(state == ST_RELEASE));

   p_zero_len_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IDLE) && start && len_zero) |=> (state == ST_IDLE));
endmodule

// File: rtl/slot_dma_addr_gen.sv
// Holds the running address, remaining count and direction; presents the
// address at the address point of each transfer slot cycle.
module slot_dma_addr_gen #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              finish,
   input  logic              present,
   input  logic [CNT_W-1:0]  len_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              write_in,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_oe,
   output logic              rw_o,
   output logic              last
);
   logic [ADDR_W-1:0] cur_q;
   logic [CNT_W-1:0]  remain_q;
   logic              wr_q;

   assign last = (remain_q == CNT_W'(1));
   assign rw_o = wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q    <= '0;
         remain_q <= '0;
         wr_q     <= 1'b0;
      end else if (load) begin
         cur_q    <= addr_in;
         remain_q <= len_in;
         wr_q     <= write_in;
      end else if (step) begin
         cur_q    <= cur_q + ADDR_W'(1);
         remain_q <= remain_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o  <= '0;
         addr_oe <= 1'b0;
      end else if (finish) begin
         addr_oe <= 1'b0;
      end else if (present) begin
         addr_o  <= cur_q;
         addr_oe <= 1'b1;
      end
   end

   // R5: an address is only ever driven with transfers still owed
   p_remain_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
      addr_oe |-> (remain_q != '0));
endmodule

// File: rtl/slot_dma_seq.sv
module slot_dma_seq
   import slot_dma_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int REQ_DLY     = 4,
   parameter int ADDR_DLY    = 6,
   parameter int CLK_NS      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_ph,
   input  logic              start,
   input  logic [CNT_W-1:0]  xfer_len,
   input  logic [ADDR_W-1:0] xfer_addr,
   input  logic              xfer_write,
   output logic              dma_req_oe,
   output logic              dma_req_val,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_oe,
   output logic              rw_o,
   output logic              busy,
   output logic              done
);
   localparam int TICK_W = $clog2(SYNC_STAGES + REQ_DLY + ADDR_DLY + 4) + 1;
   localparam logic [TICK_W-1:0] EDGE_T  = TICK_W'(REQ_DLY + 1);
   localparam logic [TICK_W-1:0] FLOAT_T = TICK_W'(REQ_DLY + 2);

   if ((SYNC_STAGES + REQ_DLY) * CLK_NS > 100) begin : g_bad_req_window
      $error("slot_dma_seq: request edge falls outside the 100 ns window");
   end
   if ((SYNC_STAGES + REQ_DLY + ADDR_DLY) * CLK_NS > 120) begin : g_bad_addr_window
      $error("slot_dma_seq: address settles later than 120 ns");
   end

   dma_state_e        state;
   logic              at_req, at_addr, load, step, finish, last;
   logic [TICK_W-1:0] tick;

   slot_phase_timer #(
      .SYNC_STAGES(SYNC_STAGES), .REQ_DLY(REQ_DLY),
      .ADDR_DLY(ADDR_DLY), .TICK_W(TICK_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .slot_ph(slot_ph),
      .at_req(at_req), .at_addr(at_addr), .tick(tick)
   );

   slot_dma_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .len_zero(xfer_len == '0), .at_req(at_req), .last(last),
      .state(state), .load(load), .step(step), .finish(finish), .done(done)
   );

   slot_dma_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .finish(finish),
      .present((state == ST_TRANSFER) && at_addr),
      .len_in(xfer_len), .addr_in(xfer_addr), .write_in(xfer_write),
      .addr_o(addr_o), .addr_oe(addr_oe), .rw_o(rw_o), .last(last)
   );

   assign dma_req_oe  = (state == ST_TRANSFER) || (state == ST_RELEASE);
   assign dma_req_val = (state == ST_RELEASE);
   assign busy        = (state != ST_IDLE);

   p_req_edge_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({dma_req_oe, dma_req_val}) |-> (tick == EDGE_T || tick == FLOAT_T));

   p_addr_under_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      addr_oe |-> (dma_req_oe && !dma_req_val));

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!addr_oe && !(dma_req_oe && !dma_req_val)));
endmodule

// File: tb/slot_dma_seq_tb.sv
module slot_dma_seq_tb;
   localparam int ADDR_W   = 16;
   localparam int CNT_W    = 8;
   localparam int REQ_DLY  = 4;
   localparam int ADDR_DLY = 6;
   localparam int SLOT_PER = 40;
   localparam int SF_EDGE  = REQ_DLY + 1;   // SYNC_STAGES(2) + REQ_DLY - 1
   localparam int SF_ADDR  = SF_EDGE + ADDR_DLY;

   logic clk = 1'b0;
   logic rst_n, slot_ph, start, xfer_write;
   logic [CNT_W-1:0]  xfer_len;
   logic [ADDR_W-1:0] xfer_addr;
   logic dma_req_oe, dma_req_val, addr_oe, rw_o, busy, done;
   logic [ADDR_W-1:0] addr_o;

   always #2.5 clk = ~clk;

   slot_dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REQ_DLY(REQ_DLY),
                  .ADDR_DLY(ADDR_DLY)) u_dut (
      .clk(clk), .rst_n(rst_n), .slot_ph(slot_ph), .start(start),
      .xfer_len(xfer_len), .xfer_addr(xfer_addr), .xfer_write(xfer_write),
      .dma_req_oe(dma_req_oe), .dma_req_val(dma_req_val), .addr_o(addr_o),
      .addr_oe(addr_oe), .rw_o(rw_o), .busy(busy), .done(done)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] base, input int i);
      return base + ADDR_W'(i);
   endfunction

   // slot phase: high SLOT_PER/2, low SLOT_PER/2, changed on falling clk
   initial begin
      slot_ph = 1'b1;
      forever begin
         repeat (SLOT_PER / 2) @(negedge clk);
         slot_ph = ~slot_ph;
      end
   end

   // monitor state
   int cyc = 0, sf = 100, assert_cyc = 0, release_cyc = 0, n_assert = 0, n_cap = 0;
   bit prev_ph = 1'b1, prev_oe = 1'b0, prev_val = 1'b0, prev_aoe = 1'b0;
   bit expect_done = 1'b0, exp_wr = 1'b0;
   logic [ADDR_W-1:0] prev_addr = '0;
   logic [ADDR_W-1:0] cap [64];

   initial begin
      forever begin
         @(posedge clk);
         #1;
         cyc++;
         if (!slot_ph && prev_ph) sf = 0; else sf++;
         prev_ph = slot_ph;
         if (rst_n) begin
            if (expect_done) begin
               chk(done && !busy && !dma_req_oe, "R8 done/busy/float after release",
                   {done, busy, dma_req_oe}, 3'b100);
               expect_done = 1'b0;
            end else if (done) begin
               chk(1'b0, "R8 unexpected done", 1, 0);
            end
            if ({dma_req_oe, dma_req_val} != {prev_oe, prev_val}) begin
               chk(sf == SF_EDGE || sf == SF_EDGE + 1, "R3 request edge timing", sf, SF_EDGE);
               if (dma_req_oe && !dma_req_val) begin
                  chk(sf == SF_EDGE, "R2 assert point", sf, SF_EDGE);
                  assert_cyc = cyc;
                  n_assert++;
               end
               if (dma_req_oe && dma_req_val) begin
                  chk(prev_oe && !prev_val, "R7 pulse follows request", {prev_oe, prev_val}, 2'b10);
                  chk(!addr_oe, "R7 address floated in pulse", addr_oe, 0);
                  release_cyc = cyc;
                  expect_done = 1'b1;
               end
               if (!dma_req_oe)
                  chk(prev_val && sf == SF_EDGE + 1, "R7 float after one pulse tick", sf, SF_EDGE + 1);
            end
            if (addr_oe && (!prev_aoe || addr_o != prev_addr)) begin
               chk(sf == SF_ADDR, "R4 address timing", sf, SF_ADDR);
               chk(rw_o == exp_wr, "R10 direction", rw_o, exp_wr);
               if (n_cap < 64) cap[n_cap] = addr_o;
               n_cap++;
            end
         end
         prev_oe = dma_req_oe; prev_val = dma_req_val;
         prev_aoe = addr_oe;   prev_addr = addr_o;
      end
   end

   task automatic run_xfer(input int len, input logic [ADDR_W-1:0] base, input bit wr, input bit poke);
      int na0, start_cyc;
      na0    = n_assert;
      n_cap  = 0;
      exp_wr = wr;
      @(negedge clk);
      start = 1'b1; xfer_len = CNT_W'(len); xfer_addr = base; xfer_write = wr;
      @(posedge clk); #2;
      start_cyc = cyc;
      chk(busy, "R2 busy after start", busy, 1);
      @(negedge clk);
      start = 1'b0; xfer_addr = ~base; xfer_write = ~wr;
      if (poke) begin
         repeat (SLOT_PER) @(negedge clk);
         start = 1'b1; xfer_len = CNT_W'(5); xfer_addr = 16'h1234;
         @(negedge clk);
         start = 1'b0;
      end
      for (int w = 0; w < (len + 3) * SLOT_PER; w++) begin
         @(posedge clk); #2;
         if (!busy) break;
      end
      chk(!busy, "R8 busy clears", busy, 0);
      chk(n_assert == na0 + 1, "R2 one request per start", n_assert - na0, 1);
      chk(assert_cyc - start_cyc <= SLOT_PER + SF_EDGE, "R2 request at first point",
          assert_cyc - start_cyc, SLOT_PER + SF_EDGE);
      chk(release_cyc - assert_cyc == len * SLOT_PER, "R6 hold length",
          release_cyc - assert_cyc, len * SLOT_PER);
      chk(n_cap == len, "R5 address count", n_cap, len);
      for (int i = 0; i < len && i < 64; i++)
         chk(cap[i] == exp_addr(base, i), "R5 address value", cap[i], exp_addr(base, i));
      repeat (3) @(posedge clk);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int seed_init;
      int na0;
      seed_init = $urandom(32'h5eed);
      rst_n = 1'b0; start = 1'b0; xfer_len = '0; xfer_addr = '0; xfer_write = 1'b0;
      repeat (5) @(negedge clk);
      chk(!dma_req_oe && !addr_oe && !busy && !done, "R1 reset state",
          {dma_req_oe, addr_oe, busy, done}, 0);
      rst_n = 1'b1;
      @(posedge clk); #2;
      chk(!dma_req_oe && !addr_oe && !busy && !done, "R1 after reset",
          {dma_req_oe, addr_oe, busy, done}, 0);

      run_xfer(1, 16'h0100, 1'b0, 1'b0);
      run_xfer(3, 16'hFFFE, 1'b1, 1'b0);        // wraps to 0000
      run_xfer(4, 16'h2000, 1'b0, 1'b1);        // R9 start while busy ignored

      // R9: zero-length start ignored
      na0 = n_assert;
      @(negedge clk);
      start = 1'b1; xfer_len = '0; xfer_addr = 16'h0055;
      @(negedge clk);
      start = 1'b0;
      repeat (2 * SLOT_PER) @(posedge clk);
      #2;
      chk(!busy, "R9 zero length stays idle", busy, 0);
      chk(n_assert == na0 && !dma_req_oe, "R9 zero length no request", n_assert - na0, 0);

      for (int i = 0; i < 8; i++) begin
         int len;
         logic [ADDR_W-1:0] base;
         bit wr;
         len  = 1 + int'($urandom % 6);
         base = ADDR_W'($urandom);
         wr   = bit'($urandom % 2);
         run_xfer(len, base, wr, 1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule